// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves a 32-bit virtual address into a physical translation after a TLB miss. It reads a two-level page table that sits in physical memory. The walker receives the missing virtual address, the kind of access that missed (read, write or execute) and the root page number of the active table. It then issues single-word reads to a physical memory port and ends with one of two results. The first is a refill entry for the TLB, with the virtual page number, the physical page number, the permission bits and a flag for a large page. The second is a fault code.

The virtual address divides into three fields. The top ten bits index the root table, the next ten bits index a second-level table, and the low twelve bits are the byte offset within a 4 KiB page. Table reads bypass translation. Each page-table entry (PTE) is one 32-bit word with these fields:

- bit 0: valid
- bits 3:1: permissions, as execute/write/read from bit 3 down to bit 1
- bits 9:4: reserved
- bits 31:10: physical page number

A valid entry whose three permission bits are all zero points to the next table. Any other valid entry is a leaf. A leaf found in the root table maps a 4 MiB megapage and ends the walk after one read.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, and `mem_req`, `done_valid` and `refill_we` are 0.
- R2: The first read of a walk goes to physical address `ptbr_ppn*4096 + va[31:22]*4`. The root page number is taken from `ptbr_ppn` in the cycle the request is accepted.
- R3: When the root entry is a pointer (valid, permissions 000), the second read goes to `pte_ppn*4096 + va[21:12]*4`.
- R4: An entry whose valid bit is 0, at either level, ends the walk with `fault_kind` = 01 (page fault) and no refill.
- R5: A leaf in the root table is a megapage. If the low ten bits of its page number are not zero, the walk ends with a page fault (01). This alignment check comes before the permission check.
- R6: A present leaf is checked against the access type. `req_acc` 00 (read) needs bit 1, 01 (write) needs bit 2 and 10 (execute) needs bit 3. Code 11 is never permitted. A denied access ends with `fault_kind` = 10 (protection fault) and no refill.
- R7: A pointer entry found in the second-level table ends the walk with a page fault (01).
- R8: On success, `refill_we` and `done_valid` are 1 with `fault_kind` = 00. The outputs then carry the following:
  - `refill_vpn` is `va[31:12]`.
  - `refill_ppn` and `refill_perm` come from the leaf.
  - `refill_mega` is 1 for a root-level leaf.
  - `pa_out` is `{ppn, va[11:0]}` for a base page, or `{ppn[21:10], va[21:0]}` for a megapage.
- R9: A request is taken only while `req_ready` is 1. A `req_valid` raised during a walk is ignored and does not change that walk's result.
- R10: `done_valid` is high for exactly one cycle, and `req_ready` is 1 in the cycle after it.
- R11: `mem_req` is never high for two cycles in a row. A base-page walk performs exactly two reads, and any walk that ends at the root performs one.
- R12: An entry with any of its reserved bits 9:4 set ends the walk with a page fault (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address that missed |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 none |
| ptbr_ppn | input | 22 | Page number of the root table |
| mem_req | output | 1 | Read request for one table word |
| mem_addr | output | 34 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read |
| done_valid | output | 1 | Walk finished (one cycle) |
| fault_kind | output | 2 | 00 none, 01 page fault, 10 protection fault |
| refill_we | output | 1 | TLB refill strobe |
| refill_vpn | output | 20 | Virtual page number for the refill |
| refill_ppn | output | 22 | Physical page number for the refill |
| refill_perm | output | 3 | Permissions {X,W,R} |
| refill_mega | output | 1 | Refill maps a 4 MiB megapage |
| pa_out | output | 34 | Translated physical address |

## Verification
The bench builds the walker with its default split: 10-bit indexes, 12-bit offset and 22-bit page numbers. These widths let a small sparse memory hold a root table and one second-level table, and still reach both the last root index (1023) and the top physical page of a megapage. With a 12-bit offset, a megapage leaf whose page number has a nonzero low ten bits can be placed directly, so the misalignment fault is reached, along with offsets at the 4 KiB and 4 MiB page edges.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int IDX_W = 10;
  parameter int OFF_W = 12;
  parameter int PPN_W = 22;
  parameter int PTE_W = 32;

  localparam int VPN_W  = 2 * IDX_W;
  localparam int VA_W   = VPN_W + OFF_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int PERM_W = 3;
  localparam int RSV_LO = PERM_W + 1;
  localparam int RSV_HI = PTE_W - PPN_W - 1;
  localparam int MEGA_W = IDX_W + OFF_W;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE, S_FAULT
  } walk_st_e;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_NONE = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2} flt_e;
  typedef enum logic [1:0] {PC_NEXT, PC_LEAF, PC_PAGE, PC_PROT} pte_cls_e;

  // permission bits are {X,W,R}
  function automatic logic perm_ok(logic [PERM_W-1:0] perm, logic [1:0] acc);
    case (acc_e'(acc))
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] pte_addr(logic [PPN_W-1:0] base, logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} | PA_W'({idx, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] compose_pa(logic [PPN_W-1:0] ppn, logic [VA_W-1:0] va,
                                                 logic mega);
    return mega ? {ppn[PPN_W-1:IDX_W], va[MEGA_W-1:0]} : {ppn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VPN_W-1:0] vpn,
  input  logic [PPN_W-1:0] base,
  input  logic             root_lvl,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx;
  assign idx  = root_lvl ? vpn[VPN_W-1 -: IDX_W] : vpn[IDX_W-1:0];
  assign addr = pte_addr(base, idx);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]  pte,
  input  logic              at_root,
  input  logic [1:0]        acc,
  output pte_cls_e          cls,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  logic valid, rsv_set, is_ptr, misaligned;
  assign valid      = pte[0];
  assign perm       = pte[PERM_W:1];
  assign ppn        = pte[PTE_W-1 -: PPN_W];
  assign rsv_set    = |pte[RSV_HI:RSV_LO];
  assign is_ptr     = (perm == '0);
  assign misaligned = at_root && (ppn[IDX_W-1:0] != '0);

  // order: presence, structure, alignment, then permission
  always_comb begin
    if (!valid || rsv_set)     cls = PC_PAGE;
    else if (is_ptr)           cls = at_root ? PC_NEXT : PC_PAGE;
    else if (misaligned)       cls = PC_PAGE;
    else if (!perm_ok(perm, acc)) cls = PC_PROT;
    else                       cls = PC_LEAF;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  input  logic [PPN_W-1:0]  ptbr_ppn,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [1:0]        fault_kind,
  output logic              refill_we,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic [PERM_W-1:0] refill_perm,
  output logic              refill_mega,
  output logic [PA_W-1:0]   pa_out
);
  walk_st_e          st;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic [PPN_W-1:0]  base_q;
  logic [PPN_W-1:0]  res_ppn;
  logic [PERM_W-1:0] res_perm;
  logic              res_mega;
  flt_e              res_flt;

  // named internal events
  logic     walk_accept, pte_arrive, at_root;
  pte_cls_e ev_cls;
  logic [PPN_W-1:0]  ev_ppn;
  logic [PERM_W-1:0] ev_perm;

  assign walk_accept = (st == S_IDLE) && req_valid;
  assign at_root     = (st == S_L1_WAIT);
  assign pte_arrive  = ((st == S_L1_WAIT) || (st == S_L2_WAIT)) && mem_rsp_valid;

  ptw_addr_gen u_addr (
    .vpn      (va_q[VA_W-1:OFF_W]),
    .base     (base_q),
    .root_lvl (st == S_L1_REQ),
    .addr     (mem_addr)
  );

  ptw_pte_eval u_eval (
    .pte     (mem_rsp_data),
    .at_root (at_root),
    .acc     (acc_q),
    .cls     (ev_cls),
    .ppn     (ev_ppn),
    .perm    (ev_perm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      base_q   <= '0;
      res_ppn  <= '0;
      res_perm <= '0;
      res_mega <= 1'b0;
      res_flt  <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (walk_accept) begin
          va_q   <= req_va;
          acc_q  <= req_acc;
          base_q <= ptbr_ppn;
          st     <= S_L1_REQ;
        end
        S_L1_REQ: st <= S_L1_WAIT;
        S_L2_REQ: st <= S_L2_WAIT;
        S_L1_WAIT, S_L2_WAIT: if (pte_arrive) begin
          case (ev_cls)
            PC_NEXT: begin
              base_q <= ev_ppn;
              st     <= S_L2_REQ;
            end
            PC_LEAF: begin
              res_ppn  <= ev_ppn;
              res_perm <= ev_perm;
              res_mega <= at_root;
              res_flt  <= FLT_NONE;
              st       <= S_DONE;
            end
            PC_PAGE: begin
              res_flt <= FLT_PAGE;
              st      <= S_FAULT;
            end
            default: begin
              res_flt <= FLT_PROT;
              st      <= S_FAULT;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign mem_req     = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign done_valid  = (st == S_DONE) || (st == S_FAULT);
  assign refill_we   = (st == S_DONE);
  assign fault_kind  = (st == S_FAULT) ? res_flt : FLT_NONE;
  assign refill_vpn  = va_q[VA_W-1:OFF_W];
  assign refill_ppn  = res_ppn;
  assign refill_perm = res_perm;
  assign refill_mega = res_mega;
  assign pa_out      = compose_pa(res_ppn, va_q, res_mega);

  p_single_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));
  p_refill_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_we |-> $past(mem_rsp_valid));
  p_fault_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_kind != 2'b00) |-> $past(mem_rsp_valid));
  p_mega_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_we && refill_mega) |-> (refill_ppn[IDX_W-1:0] == '0));
  p_no_refill_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_kind != 2'b00) |-> !refill_we);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  import ptw_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [21:0] ptbr_ppn = 22'h100;
  logic mem_req;
  logic [33:0] mem_addr;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic done_valid;
  logic [1:0] fault_kind;
  logic refill_we;
  logic [19:0] refill_vpn;
  logic [21:0] refill_ppn;
  logic [2:0]  refill_perm;
  logic refill_mega;
  logic [33:0] pa_out;

  always #4 clk = ~clk;

  pt_walker u0 (.*);

  bit [31:0] mem [bit [31:0]];
  int rd_cnt = 0;
  logic [33:0] a_log [0:1023];
  int n_chk = 0, n_err = 0;

  function automatic logic [31:0] rd(logic [33:0] a);
    return mem.exists(a[33:2]) ? mem[a[33:2]] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req;
      if (mem_req) begin
        mem_rsp_data        <= rd(mem_addr);
        a_log[rd_cnt % 1024] <= mem_addr;
        rd_cnt              <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit allowed(logic [2:0] pm, logic [1:0] acc);
    if (acc == 2'd3) return 1'b0;
    return pm[acc];
  endfunction

  // independent reference walk
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] acc,
                          output logic [1:0] flt, output logic [21:0] ppn, output logic [2:0] pm,
                          output bit mega, output logic [33:0] pa, output int nrd,
                          output logic [33:0] a1, output logic [33:0] a2);
    logic [31:0] e;
    a1 = 34'(ptbr_ppn) * 4096 + 34'(va >> 22) * 4;
    a2 = '0; nrd = 1; mega = 1'b1; flt = 2'd0;
    e = rd(a1);
    ppn = e[31:10]; pm = e[3:1]; pa = '0;
    if (!e[0] || e[9:4] != 0) begin flt = 2'd1; return; end
    if (pm == 0) begin
      mega = 1'b0;
      a2 = 34'(e[31:10]) * 4096 + 34'((va >> 12) & 32'h3FF) * 4;
      nrd = 2;
      e = rd(a2);
      ppn = e[31:10]; pm = e[3:1];
      if (!e[0] || e[9:4] != 0 || pm == 0) begin flt = 2'd1; return; end
      if (!allowed(pm, acc)) begin flt = 2'd2; return; end
      pa = 34'(ppn) * 4096 + 34'(va & 32'hFFF);
    end else begin
      if ((ppn & 22'h3FF) != 0) begin flt = 2'd1; return; end
      if (!allowed(pm, acc)) begin flt = 2'd2; return; end
      pa = (34'(ppn >> 10) << 22) | 34'(va & 32'h3FFFFF);
    end
  endtask

  logic [1:0] o_flt; logic o_we, o_mega; logic [21:0] o_ppn; logic [2:0] o_pm;
  logic [33:0] o_pa; logic [19:0] o_vpn; int o_rd0, o_rd1; bit o_seen;

  // busy_va != 0: a competing request is raised during the walk
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] busy_va);
    o_rd0 = rd_cnt; o_seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    if (busy_va != 0) begin
      req_valid = 1'b1; req_va = busy_va; req_acc = 2'd0;
      chk(req_ready == 1'b0, "R9", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R9", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
    end
    for (int t = 0; t < 40 && !o_seen; t++) begin
      if (done_valid) begin
        o_seen = 1; o_flt = fault_kind; o_we = refill_we; o_mega = refill_mega;
        o_ppn = refill_ppn; o_pm = refill_perm; o_pa = pa_out; o_vpn = refill_vpn;
      end else @(negedge clk);
    end
    o_rd1 = rd_cnt;
    chk(o_seen, "R10", 64'(o_seen), 64'd1);
    @(negedge clk);
    chk(!done_valid && req_ready, "R10", {done_valid, req_ready}, 64'b01);
  endtask

  task automatic run_check(input logic [31:0] va, input logic [1:0] acc, input string tag,
                           input logic [31:0] busy_va);
    logic [1:0] e_flt; logic [21:0] e_ppn; logic [2:0] e_pm; bit e_mega;
    logic [33:0] e_pa, e_a1, e_a2; int e_nrd; string rq;
    ref_walk(va, acc, e_flt, e_ppn, e_pm, e_mega, e_pa, e_nrd, e_a1, e_a2);
    walk(va, acc, busy_va);
    if (tag != "") rq = tag;
    else if (e_flt == 2'd0) rq = "R8";
    else if (e_flt == 2'd2) rq = "R6";
    else rq = e_mega ? "R5" : "R4";
    chk(o_flt == e_flt, rq, 64'(o_flt), 64'(e_flt));
    chk(o_we == (e_flt == 2'd0), rq, 64'(o_we), 64'(e_flt == 2'd0));
    if (e_flt == 2'd0) begin
      chk({o_ppn, o_pm, o_mega} == {e_ppn, e_pm, e_mega}, "R8",
          64'({o_ppn, o_pm, o_mega}), 64'({e_ppn, e_pm, e_mega}));
      chk(o_pa == e_pa && o_vpn == va[31:12], "R8", 64'(o_pa), 64'(e_pa));
    end
    chk(o_rd1 - o_rd0 == e_nrd, "R11", 64'(o_rd1 - o_rd0), 64'(e_nrd));
    chk(a_log[o_rd0 % 1024] == e_a1, "R2", 64'(a_log[o_rd0 % 1024]), 64'(e_a1));
    if (e_nrd == 2)
      chk(a_log[(o_rd0 + 1) % 1024] == e_a2, "R3", 64'(a_log[(o_rd0 + 1) % 1024]), 64'(e_a2));
  endtask

  localparam int NV = 16;
  // {acc, va}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 32'h0040_0123},  // base page, read ok
    {2'd2, 32'h0040_0123},  // base page, execute ok
    {2'd1, 32'h0040_0123},  // write denied
    {2'd1, 32'h0040_1FFF},  // last byte of page, write ok
    {2'd0, 32'h0040_2000},  // invalid second-level entry
    {2'd0, 32'h0040_3000},  // pointer at second level (R7)
    {2'd1, 32'h0040_5010},  // read-only, write denied
    {2'd0, 32'h0040_5010},  // read-only, read ok
    {2'd0, 32'h00BA_BCDE},  // megapage read ok
    {2'd2, 32'h00BA_BCDE},  // megapage execute denied
    {2'd0, 32'h00C0_0000},  // misaligned megapage
    {2'd0, 32'h0100_0000},  // invalid root entry
    {2'd0, 32'h0140_0000},  // execute-only, read denied
    {2'd2, 32'h0140_0000},  // execute-only, execute ok
    {2'd1, 32'hFFFF_FFFF},  // last root index, megapage top
    {2'd3, 32'h0040_0123}   // access code 11 never allowed
  };

  initial begin
    bit done_flag;
    mem[32'h40000 + 1]    = 32'h0008_0001;  // pointer to table at 0x200
    mem[32'h40000 + 2]    = 32'h0010_0007;  // mega ppn 0x400 RW
    mem[32'h40000 + 3]    = 32'h0010_0403;  // mega ppn 0x401 R, misaligned
    mem[32'h40000 + 5]    = 32'h0020_0009;  // mega ppn 0x800 X
    mem[32'h40000 + 6]    = 32'h0010_0013;  // reserved bit set
    mem[32'h40000 + 1023] = 32'hFFF0_000F;  // mega ppn 0x3FFC00 RWX
    mem[32'h80000 + 0]    = 32'h048D_140B;  // ppn 0x12345 RX
    mem[32'h80000 + 1]    = 32'h002A_F007;  // ppn 0xABC RW
    mem[32'h80000 + 3]    = 32'h0000_0001;  // pointer at level two
    mem[32'h80000 + 5]    = 32'h001D_DC03;  // ppn 0x777 R
    mem[32'h80000 + 6]    = 32'h0001_4203;  // reserved bit set

    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done_valid && !refill_we, "R1",
        {req_ready, mem_req, done_valid, refill_we}, 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !done_valid, "R1", {req_ready, mem_req, done_valid}, 64'b100);

    for (int i = 0; i < NV; i++) run_check(VEC[i][31:0], VEC[i][33:32], "", 32'h0);

    run_check(32'h0040_3000, 2'd0, "R7", 32'h0);
    run_check(32'h0180_0000, 2'd0, "R12", 32'h0);
    run_check(32'h0040_6000, 2'd0, "R12", 32'h0);
    run_check(32'h00C0_0000, 2'd2, "R5", 32'h0);   // misaligned beats permission
    run_check(32'h0040_1ABC, 2'd0, "R9", 32'h00BA_BCDE);

    // idle with no request: nothing starts (R9)
    o_rd0 = rd_cnt;
    repeat (4) @(negedge clk);
    chk(rd_cnt == o_rd0 && req_ready && !done_valid, "R9", 64'(rd_cnt - o_rd0), 64'd0);

    // new root register value (R2)
    ptbr_ppn = 22'h200;
    run_check(32'h0000_0000, 2'd0, "R2", 32'h0);
    ptbr_ppn = 22'h100;

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule